// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer ratio and emits one registered pulse per period. It is intended for the feedback path of a phase-locked loop, where the pulse train is compared against a divided reference. Inside, a small prescaler alternates between dividing by four and by five. A main counter counts prescaler cycles per output period, and a swallow counter sets how many of those cycles use the longer division. The binary ratio N on the modulus input is split into a main count M = N >> 2 and a swallow count A = N & 3, so that N = 4·M + A.

Software or a control FSM presents a ratio together with a one-cycle load strobe. Each loaded value is checked for legality. A legal value is held pending and takes over only at the next period boundary, so that no period is cut short. An illegal value raises a flag and leaves the divider running on its last accepted ratio. After reset the divider runs at a parameterised default ratio of 12.

Top module: `fbdiv_dualmod`

## Requirements
- R1: For every legal ratio N from 4 up to 16383, `pulse_o` is high exactly once every N cycles of `clk_i`.
- R2: Within each output period, the prescaler divides by 5 for the first A prescaler cycles and by 4 for the remaining M − A cycles. The swallow count never exceeds the remaining main count. The boundary ratio 15 (M = 3, A = 3) divides correctly.
- R3: A ratio is legal exactly when M ≥ 1 and A ≤ M. This admits 4, 5, 8, 9, 10 and every value from 12 upward, and rejects 0 to 3, 6, 7 and 11.
- R4: On the cycle after a load strobe, `bad_mod_o` is 1 if the loaded ratio was illegal and 0 if it was legal. Between strobes, `bad_mod_o` holds its value.
- R5: An illegal load has no effect on the division. The running period and all later periods keep the last legal ratio, and this includes a legal ratio still pending from earlier in the same period.
- R6: A legal ratio loaded in the middle of a period takes effect only at the end of that period. The period in progress completes with the old ratio, and the next one uses the new ratio.
- R7: `pulse_o` comes straight from a flip-flop and is never high for two consecutive cycles.
- R8: Asserting `rst_ni` low drives `pulse_o` and `bad_mod_o` to 0 at once, without waiting for a clock edge. The ratio returns to 12. Release passes through a two-stage synchronizer, so the first pulse appears on the 14th rising edge after `rst_ni` goes high.
- R9: If several legal ratios are loaded within one period, the last one loaded is the one applied at the period boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mod_i | input | 14 | Requested division ratio, plain binary |
| load_i | input | 1 | One-cycle strobe that samples `mod_i` |
| pulse_o | output | 1 | Registered one-cycle pulse, once per period |
| bad_mod_o | output | 1 | Set when the last loaded ratio was rejected |

## Verification
The bench counts the clock cycles between pulses for ratios taken from both the sparse low range and the continuous range, up to the 14-bit maximum, with rejected values placed between them.

Each corner case targets a specific fault:
- A divider that swapped the order of long and short prescaler cycles, or let the swallow count run past the main count, would miscount at 9, 10 and 15.
- A divider that applied a new ratio at once would shorten the period in which the load happened.
- A divider that let a rejected value through, or dropped a pending legal value when a rejected one followed it, would change period length after the flag rose.

Reset is also applied in the middle of a run, to show that the flag clears without a clock and that the default ratio returns.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int unsigned FB_MOD_W_DEF     = 14;
  localparam int unsigned FB_PRE_W_DEF     = 2;
  localparam int unsigned FB_RESET_MOD_DEF = 12;

  // Prescaler division select: short = 2**PRE_W, long = 2**PRE_W + 1
  typedef enum logic {
    PRE_SHORT = 1'b0,
    PRE_LONG  = 1'b1
  } pre_mode_e;
endpackage

// File: rtl/fbdiv_rstsync.sv
module fbdiv_rstsync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  assign sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/fbdiv_modchk.sv
module fbdiv_modchk #(
  parameter int unsigned MOD_W = fbdiv_pkg::FB_MOD_W_DEF,
  parameter int unsigned PRE_W = fbdiv_pkg::FB_PRE_W_DEF
) (
  input  logic [MOD_W-1:0] mod_i,
  output logic             legal_o
);
  localparam int unsigned MAIN_W = MOD_W - PRE_W;
  localparam int unsigned PRE_P  = 1 << PRE_W;

  logic [MAIN_W-1:0] main_w;
  logic [PRE_W-1:0]  swal_w;

  assign main_w  = mod_i[MOD_W-1:PRE_W];
  assign swal_w  = mod_i[PRE_W-1:0];
  // Swallow cycles must fit inside the main cycles of one period
  assign legal_o = (main_w != '0) && (MAIN_W'(swal_w) <= main_w);

  always_comb begin
    AST_LEGAL_FLOOR: assert (!legal_o || (mod_i >= MOD_W'(PRE_P))); // R3
  end
endmodule

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler #(
  parameter int unsigned PRE_W = fbdiv_pkg::FB_PRE_W_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  fbdiv_pkg::pre_mode_e  mode_i,
  output logic                  wrap_o
);
  import fbdiv_pkg::*;

  localparam int unsigned PC_W   = PRE_W + 1;
  localparam logic [PC_W-1:0] LAST_S = PC_W'((1 << PRE_W) - 1);
  localparam logic [PC_W-1:0] LAST_L = PC_W'(1 << PRE_W);

  logic [PC_W-1:0] pcnt_q;
  logic [PC_W-1:0] pcnt_d;
  logic [PC_W-1:0] last_w;

  assign last_w = (mode_i == PRE_LONG) ? LAST_L : LAST_S;
  assign wrap_o = (pcnt_q == last_w);

  always_comb begin
    if (wrap_o) begin
      pcnt_d = '0;
    end else begin
      pcnt_d = pcnt_q + PC_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
    end
  end

  // The mode may only move at a prescaler boundary
  AST_PRE_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcnt_q != '0) |-> $stable(mode_i)); // R2
  AST_PRE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= LAST_L); // R1
endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow #(
  parameter int unsigned MOD_W     = fbdiv_pkg::FB_MOD_W_DEF,
  parameter int unsigned PRE_W     = fbdiv_pkg::FB_PRE_W_DEF,
  parameter int unsigned RESET_MOD = fbdiv_pkg::FB_RESET_MOD_DEF
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wrap_i,
  input  logic [MOD_W-PRE_W-1:0]    rld_main_i,
  input  logic [PRE_W-1:0]          rld_swal_i,
  output fbdiv_pkg::pre_mode_e      mode_o,
  output logic                      end_o
);
  import fbdiv_pkg::*;

  localparam int unsigned MAIN_W = MOD_W - PRE_W;
  localparam logic [MOD_W-1:0]  RST_WORD = MOD_W'(RESET_MOD);
  localparam logic [MAIN_W-1:0] RST_MAIN = RST_WORD[MOD_W-1:PRE_W];
  localparam logic [PRE_W-1:0]  RST_SWAL = RST_WORD[PRE_W-1:0];

  logic [MAIN_W-1:0] mcnt_q, mcnt_d;
  logic [PRE_W-1:0]  scnt_q, scnt_d;
  logic              cnt_en;

  assign cnt_en = wrap_i;
  assign end_o  = wrap_i && (mcnt_q == MAIN_W'(1));
  assign mode_o = (scnt_q != '0) ? PRE_LONG : PRE_SHORT;

  always_comb begin
    mcnt_d = mcnt_q;
    scnt_d = scnt_q;
    if (end_o) begin
      mcnt_d = rld_main_i;
      scnt_d = rld_swal_i;
    end else begin
      mcnt_d = mcnt_q - MAIN_W'(1);
      if (scnt_q != '0) begin
        scnt_d = scnt_q - PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcnt_q <= RST_MAIN;
      scnt_q <= RST_SWAL;
    end else if (cnt_en) begin
      mcnt_q <= mcnt_d;
      scnt_q <= scnt_d;
    end
  end

  AST_SWALLOW_LE_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    MAIN_W'(scnt_q) <= mcnt_q); // R2
  AST_MAIN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcnt_q != '0); // R1
  AST_END_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> (mcnt_q == $past(rld_main_i))); // R6
endmodule

// File: rtl/fbdiv_dualmod.sv
module fbdiv_dualmod #(
  parameter int unsigned MOD_W     = fbdiv_pkg::FB_MOD_W_DEF,
  parameter int unsigned PRE_W     = fbdiv_pkg::FB_PRE_W_DEF,
  parameter int unsigned RESET_MOD = fbdiv_pkg::FB_RESET_MOD_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MOD_W-1:0] mod_i,
  input  logic             load_i,
  output logic             pulse_o,
  output logic             bad_mod_o
);
  import fbdiv_pkg::*;

  localparam int unsigned MAIN_W = MOD_W - PRE_W;

  logic             rst_n;
  logic             in_legal;
  logic             wrap_w;
  logic             end_w;
  pre_mode_e        mode_w;

  logic [MOD_W-1:0] act_q, act_d;
  logic [MOD_W-1:0] pend_q, pend_d;
  logic             vld_q, vld_d;
  logic             bad_q, bad_d;
  logic             pulse_q;
  logic             act_en, pend_en, bad_en;
  logic [MOD_W-1:0] next_mod;

  fbdiv_rstsync u_rstsync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  fbdiv_modchk #(.MOD_W(MOD_W), .PRE_W(PRE_W)) u_modchk (
    .mod_i   (mod_i),
    .legal_o (in_legal)
  );

  fbdiv_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .mode_i (mode_w),
    .wrap_o (wrap_w)
  );

  // Ratio for the period that starts at the next boundary
  assign next_mod = vld_q ? pend_q : act_q;

  fbdiv_swallow #(.MOD_W(MOD_W), .PRE_W(PRE_W), .RESET_MOD(RESET_MOD)) u_swal (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .wrap_i     (wrap_w),
    .rld_main_i (next_mod[MOD_W-1:PRE_W]),
    .rld_swal_i (next_mod[PRE_W-1:0]),
    .mode_o     (mode_w),
    .end_o      (end_w)
  );

  assign act_en  = end_w;
  assign pend_en = load_i && in_legal;
  assign bad_en  = load_i;

  always_comb begin
    act_d  = next_mod;
    pend_d = mod_i;
    bad_d  = !in_legal;
    vld_d  = vld_q;
    if (end_w) begin
      vld_d = 1'b0;
    end
    if (pend_en) begin
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= MOD_W'(RESET_MOD);
      pend_q  <= '0;
      vld_q   <= 1'b0;
      bad_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (act_en)  act_q  <= act_d;
      if (pend_en) pend_q <= pend_d;
      if (bad_en)  bad_q  <= bad_d;
      vld_q   <= vld_d;
      pulse_q <= end_w;
    end
  end

  assign pulse_o   = pulse_q;
  assign bad_mod_o = bad_q;

  AST_PULSE_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R7
  AST_BAD_ON_REJECT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (load_i && !in_legal) |=> bad_mod_o); // R4
  AST_BAD_OFF_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (load_i && in_legal) |=> !bad_mod_o); // R4
  AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(act_q) |-> $past(end_w)); // R6
  AST_REJECT_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_n)
    (load_i && !in_legal) |=> $stable(pend_q)); // R5
  AST_MAIN_FIELD_NZ: assert property (@(posedge clk_i) disable iff (!rst_n)
    act_q[MOD_W-1:PRE_W] != MAIN_W'(0)); // R3
endmodule

// File: tb/fbdiv_dualmod_tb.sv
module fbdiv_dualmod_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [13:0] mod_i;
  logic        load_i;
  logic        pulse_o;
  logic        bad_mod_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam int NV = 15;
  localparam int unsigned TBL_MOD [NV] = '{4, 6, 5, 7, 8, 9, 11, 10, 12, 13, 0, 100, 15, 3, 16383};
  localparam bit          TBL_OK  [NV] = '{1, 0, 1, 0, 1, 1, 0,  1,  1,  1, 0, 1,   1,  0, 1};

  always #10 clk_i = ~clk_i;

  fbdiv_dualmod u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mod_i     (mod_i),
    .load_i    (load_i),
    .pulse_o   (pulse_o),
    .bad_mod_o (bad_mod_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (pulse_o !== 1'b1 && n < 20000);
  endtask

  task automatic load_mod(input int unsigned v);
    mod_i  = 14'(v);
    load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int n;
    int last;
    rst_ni = 1'b0;
    load_i = 1'b0;
    mod_i  = '0;
    repeat (3) @(negedge clk_i);
    chk("R8 pulse in reset", int'(pulse_o), 0);
    chk("R8 flag in reset", int'(bad_mod_o), 0);
    rst_ni = 1'b1;
    wait_pulse(n);
    chk("R8 first pulse after release", n, 14);
    @(negedge clk_i);
    chk("R7 pulse one wide", int'(pulse_o), 0);
    wait_pulse(n);
    chk("R1 default ratio", n, 11);
    last = 12;

    for (int i = 0; i < NV; i++) begin
      load_mod(TBL_MOD[i]);
      chk($sformatf("R3 R4 flag for %0d", TBL_MOD[i]), int'(bad_mod_o), TBL_OK[i] ? 0 : 1);
      wait_pulse(n);
      chk(TBL_OK[i] ? "R6 old ratio finishes" : "R5 rejected ignored", n, last - 1);
      if (TBL_OK[i]) begin
        last = int'(TBL_MOD[i]);
        wait_pulse(n);
        chk((last == 15) ? "R2 ratio 15" : "R1 ratio", n, last);
        wait_pulse(n);
        chk("R1 ratio repeat", n, last);
      end else begin
        wait_pulse(n);
        chk("R5 last legal kept", n, last);
      end
    end

    // R6: load in the middle of a long period
    repeat (100) @(negedge clk_i);
    load_mod(9);
    wait_pulse(n);
    chk("R6 mid-period load", n, 16383 - 101);
    wait_pulse(n);
    chk("R6 new ratio applied", n, 9);

    // R9: two legal loads in one period
    load_mod(20);
    load_mod(30);
    wait_pulse(n);
    chk("R9 period before change", n, 7);
    wait_pulse(n);
    chk("R9 last load wins", n, 30);

    // R5: legal pending then rejected in same period
    load_mod(40);
    load_mod(11);
    chk("R4 flag after reject", int'(bad_mod_o), 1);
    wait_pulse(n);
    chk("R5 period before change", n, 28);
    wait_pulse(n);
    chk("R5 pending legal kept", n, 40);

    // R8: asynchronous reset mid-run
    load_mod(7);
    chk("R4 flag set before reset", int'(bad_mod_o), 1);
    #5;
    rst_ni = 1'b0;
    #1;
    chk("R8 flag cleared async", int'(bad_mod_o), 0);
    chk("R8 pulse low async", int'(pulse_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    wait_pulse(n);
    chk("R8 default ratio restored", n, 14);
    wait_pulse(n);
    chk("R1 default ratio after reset", n, 12);

    finish_run();
  end
endmodule